// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block passes data between two 16-bit buses, called A and B, without inverting it. The datapath is split into two 8-bit byte lanes. Each lane has its own active-low output enable, a direction bit, a capture strobe for each direction and a source select for each direction. Each direction also has its own storage register. A lane that is enabled drives one side of the block. The side that is driven shows either the live value on the opposite bus or the value held in the register for that direction. To run the block as one 16-bit transceiver, tie the per-lane controls together.

The bus pins are not real tristate pins. Each bus is modelled as a pin-input vector, a pin-output vector and a per-lane drive flag, so the design can be synthesized. The capture strobes are sampled on the system clock `clk`. A register loads from its bus pins in the clock cycle in which its strobe is seen to rise. This happens whatever the enable and direction inputs are, so a lane that is isolated can still be loaded and its contents presented later.

Top module: `xcvr_top`

## Requirements
- R1: Each 8-bit lane (lane 0 is bits 7:0, lane 1 is bits 15:8) obeys only its own controls, so two lanes may run in different directions and modes at the same time.
- R2: When `ab_cap[l]` is 1 at a clock edge and was 0 at the previous edge, the lane's A-side register takes the lane's `a_in` bits, and the new value is visible from that edge on.
- R3: When `ba_cap[l]` is 1 at a clock edge and was 0 at the previous edge, the lane's B-side register takes the lane's `b_in` bits.
- R4: Capture (R2, R3) takes place whatever the values of `oe_n` and `dir`, including while the lane is isolated.
- R5: While `oe_n[l]` is 1, `a_drv[l]` and `b_drv[l]` are both 0.
- R6: While `oe_n[l]` is 0 and `dir[l]` is 1, `b_drv[l]` is 1 and `a_drv[l]` is 0. With `ab_sel[l]` at 0, the lane's `b_out` equals its `a_in` in the same cycle.
- R7: With `oe_n[l]`=0, `dir[l]`=1 and `ab_sel[l]`=1, the lane's `b_out` equals the A-side register, so a capture updates the driven value.
- R8: While `oe_n[l]` is 0 and `dir[l]` is 0, `a_drv[l]` is 1 and `b_drv[l]` is 0. The lane's `a_out` equals its `b_in` when `ba_sel[l]` is 0, and equals the B-side register when `ba_sel[l]` is 1.
- R9: A strobe held at 1 over several edges captures only at its first edge.
- R10: A clock edge with `rst_n` at 0 clears both registers and the strobe history of every lane.
- R11: Output data bits of a lane side whose drive flag is 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-lane active-low output enable |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| ab_cap | input | 2 | Per-lane A-side capture strobe |
| ba_cap | input | 2 | Per-lane B-side capture strobe |
| ab_sel | input | 2 | Per-lane source for B: 0 live A, 1 A-side register |
| ba_sel | input | 2 | Per-lane source for A: 0 live B, 1 B-side register |
| a_in | input | 16 | Value present on the A pins |
| b_in | input | 16 | Value present on the B pins |
| a_out | output | 16 | Value the block drives onto A |
| a_drv | output | 2 | Per-lane drive flag for A |
| b_out | output | 16 | Value the block drives onto B |
| b_drv | output | 2 | Per-lane drive flag for B |

## Verification
The assertions check several properties in every cycle. No lane drives both sides at once, an isolated lane drives nothing, and the driven side follows the selected live or stored source. Each detected strobe rise loads the register with the pin value sampled at that edge, and the register holds between rises. Other behaviour can be shown only by the bench's scenarios. A value captured while a lane is isolated later appears once stored mode is switched on. A strobe held high does not reload the register. Two lanes can work independently in opposite directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int LANE_W = 8;
  typedef logic [LANE_W-1:0] lane_t;

  // Value placed on a driven side: live opposite-bus data or stored copy.
  function automatic lane_t pick_src(logic drive, logic use_store,
                                     lane_t live, lane_t stored);
    if (!drive) return '0;
    return use_store ? stored : live;
  endfunction

  // Enable/direction decode, returned as {drive_a, drive_b}.
  function automatic logic [1:0] drive_dec(logic en_n, logic to_b);
    if (en_n) return 2'b00;
    return to_b ? 2'b01 : 2'b10;
  endfunction
endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  oe_n,
  input  logic  dir,
  input  logic  ab_cap,
  input  logic  ba_cap,
  input  logic  ab_sel,
  input  logic  ba_sel,
  input  lane_t a_in,
  input  lane_t b_in,
  output lane_t a_out,
  output logic  a_drv,
  output lane_t b_out,
  output logic  b_drv,
  output lane_t a_store,
  output lane_t b_store,
  output logic  ab_evt,
  output logic  ba_evt
);
  lane_t a_q, b_q;
  logic [1:0] drv;

  xcvr_edge u_ab_edge (.clk(clk), .rst_n(rst_n), .strobe(ab_cap), .rise(ab_evt));
  xcvr_edge u_ba_edge (.clk(clk), .rst_n(rst_n), .strobe(ba_cap), .rise(ba_evt));

  // Capture is independent of enable and direction.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ab_evt) a_q <= a_in;
      if (ba_evt) b_q <= b_in;
    end
  end

  assign drv     = drive_dec(oe_n, dir);
  assign a_drv   = drv[1];
  assign b_drv   = drv[0];
  assign b_out   = pick_src(drv[0], ab_sel, a_in, a_q);
  assign a_out   = pick_src(drv[1], ba_sel, b_in, b_q);
  assign a_store = a_q;
  assign b_store = b_q;
endmodule

// File: rtl/xcvr_top.sv
module xcvr_top #(
  parameter  int LANES = 2,
  localparam int BUS_W = LANES * xcvr_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] oe_n,
  input  logic [LANES-1:0] dir,
  input  logic [LANES-1:0] ab_cap,
  input  logic [LANES-1:0] ba_cap,
  input  logic [LANES-1:0] ab_sel,
  input  logic [LANES-1:0] ba_sel,
  input  logic [BUS_W-1:0] a_in,
  input  logic [BUS_W-1:0] b_in,
  output logic [BUS_W-1:0] a_out,
  output logic [LANES-1:0] a_drv,
  output logic [BUS_W-1:0] b_out,
  output logic [LANES-1:0] b_drv
);
  localparam int LW = xcvr_pkg::LANE_W;

  // Internal events and state brought out for the checker.
  logic [BUS_W-1:0] a_store, b_store;
  logic [LANES-1:0] ab_evt, ba_evt;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .oe_n    (oe_n[l]),
      .dir     (dir[l]),
      .ab_cap  (ab_cap[l]),
      .ba_cap  (ba_cap[l]),
      .ab_sel  (ab_sel[l]),
      .ba_sel  (ba_sel[l]),
      .a_in    (a_in[l*LW +: LW]),
      .b_in    (b_in[l*LW +: LW]),
      .a_out   (a_out[l*LW +: LW]),
      .a_drv   (a_drv[l]),
      .b_out   (b_out[l*LW +: LW]),
      .b_drv   (b_drv[l]),
      .a_store (a_store[l*LW +: LW]),
      .b_store (b_store[l*LW +: LW]),
      .ab_evt  (ab_evt[l]),
      .ba_evt  (ba_evt[l])
    );
  end
endmodule

// File: rtl/xcvr_top_chk.sv
module xcvr_top_chk #(
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [LANES-1:0]      oe_n,
  input logic [LANES-1:0]      ab_sel,
  input logic [LANES-1:0]      ba_sel,
  input logic [LANES*LW-1:0]   a_in,
  input logic [LANES*LW-1:0]   b_in,
  input logic [LANES*LW-1:0]   a_out,
  input logic [LANES*LW-1:0]   b_out,
  input logic [LANES-1:0]      a_drv,
  input logic [LANES-1:0]      b_drv,
  input logic [LANES*LW-1:0]   a_store,
  input logic [LANES*LW-1:0]   b_store,
  input logic [LANES-1:0]      ab_evt,
  input logic [LANES-1:0]      ba_evt
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (a_store == '0 && b_store == '0)); // R10

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[l] |-> (!a_drv[l] && !b_drv[l])); // R5
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_drv[l] && b_drv[l])); // R6
    AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_drv[l] && !ab_sel[l]) |-> b_out[l*LW +: LW] == a_in[l*LW +: LW]); // R6
    AST_STORE_TO_B: assert property (@(posedge clk) disable iff (!rst_n)
      (b_drv[l] && ab_sel[l]) |-> b_out[l*LW +: LW] == a_store[l*LW +: LW]); // R7
    AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drv[l] && !ba_sel[l]) |-> a_out[l*LW +: LW] == b_in[l*LW +: LW]); // R8
    AST_STORE_TO_A: assert property (@(posedge clk) disable iff (!rst_n)
      (a_drv[l] && ba_sel[l]) |-> a_out[l*LW +: LW] == b_store[l*LW +: LW]); // R8
    AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
      ab_evt[l] |=> a_store[l*LW +: LW] == $past(a_in[l*LW +: LW])); // R2
    AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
      ba_evt[l] |=> b_store[l*LW +: LW] == $past(b_in[l*LW +: LW])); // R3
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_evt[l] |=> $stable(a_store[l*LW +: LW])); // R9
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
      !ba_evt[l] |=> $stable(b_store[l*LW +: LW])); // R9
    AST_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
      !a_drv[l] |-> a_out[l*LW +: LW] == '0); // R11
    AST_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
      !b_drv[l] |-> b_out[l*LW +: LW] == '0); // R11
  end
endmodule

bind xcvr_top xcvr_top_chk #(.LANES(LANES), .LW(xcvr_pkg::LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .ab_sel(ab_sel), .ba_sel(ba_sel),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_drv(a_drv), .b_drv(b_drv), .a_store(a_store), .b_store(b_store),
  .ab_evt(ab_evt), .ba_evt(ba_evt)
);

// File: tb/xcvr_top_bench.sv
`timescale 1ns/1ps
module xcvr_top_bench;
  localparam int L = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [L-1:0] oe_n = '1, dir = '0, ab_cap = '0, ba_cap = '0, ab_sel = '0, ba_sel = '0;
  logic [L*W-1:0] a_in = '0, b_in = '0;
  logic [L*W-1:0] a_out, b_out;
  logic [L-1:0] a_drv, b_drv;

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench reference state
  logic [W-1:0] m_a [L];
  logic [W-1:0] m_b [L];
  logic m_pa [L];
  logic m_pb [L];

  always #2.5 clk = ~clk;

  xcvr_top #(.LANES(L)) u_xcvr_top (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .ab_cap(ab_cap), .ba_cap(ba_cap),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
  );

  always @(posedge clk) begin
    for (int l = 0; l < L; l++) begin
      if (!rst_n) begin
        m_a[l] = '0; m_b[l] = '0; m_pa[l] = 1'b0; m_pb[l] = 1'b0;
      end else begin
        if (ab_cap[l] && !m_pa[l]) m_a[l] = a_in[l*W +: W];
        if (ba_cap[l] && !m_pb[l]) m_b[l] = b_in[l*W +: W];
        m_pa[l] = ab_cap[l];
        m_pb[l] = ba_cap[l];
      end
    end
  end

  function automatic string mode_tag(int l);
    if (oe_n[l]) return "R5";
    if (dir[l])  return ab_sel[l] ? "R7" : "R6";
    return "R8";
  endfunction

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare all lanes against the reference; tag "" picks the mode tag.
  task automatic check_all(string tag);
    #1;
    for (int l = 0; l < L; l++) begin
      logic ea, eb;
      logic [W-1:0] eao, ebo;
      string t;
      t  = (tag == "") ? mode_tag(l) : tag;
      ea = !oe_n[l] && !dir[l];
      eb = !oe_n[l] && dir[l];
      ebo = !eb ? '0 : (ab_sel[l] ? m_a[l] : a_in[l*W +: W]);
      eao = !ea ? '0 : (ba_sel[l] ? m_b[l] : b_in[l*W +: W]);
      check_val(t, {a_drv[l], b_drv[l], a_out[l*W +: W], b_out[l*W +: W]},
                {ea, eb, eao, ebo});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; oe_n = '0; dir = '1; ab_sel = '1; ba_sel = '1;
    @(negedge clk); #1;
    check_val("R10", b_out, '0);

    // Capture while isolated, then present in stored mode (R4, R2, R3, R9)
    for (int l = 0; l < L; l++) begin
      @(negedge clk);
      oe_n = '1; ab_sel = '0; ba_sel = '0;
      a_in[l*W +: W] = 8'hA5 ^ 8'(l); b_in[l*W +: W] = 8'h3C ^ 8'(l);
      ab_cap[l] = 1'b1; ba_cap[l] = 1'b1;
      @(negedge clk);
      a_in[l*W +: W] = 8'h11; b_in[l*W +: W] = 8'h22;  // strobe still high
      @(negedge clk); @(negedge clk);
      oe_n[l] = 1'b0; dir[l] = 1'b1; ab_sel[l] = 1'b1;
      #1 check_val("R4", b_out[l*W +: W], 8'hA5 ^ 8'(l));
      check_val("R9", b_out[l*W +: W], 8'hA5 ^ 8'(l));
      @(negedge clk);
      dir[l] = 1'b0; ba_sel[l] = 1'b1;
      #1 check_val("R3", a_out[l*W +: W], 8'h3C ^ 8'(l));
      @(negedge clk);
      ab_cap[l] = 1'b0; ba_cap[l] = 1'b0;
      @(negedge clk);
      ab_cap[l] = 1'b1; a_in[l*W +: W] = 8'h5A; dir[l] = 1'b1;
      @(negedge clk);
      #1 check_val("R2", b_out[l*W +: W], 8'h5A);
      ab_cap[l] = 1'b0;
    end

    // Lanes in opposite directions at once (R1, R11)
    @(negedge clk);
    oe_n = '0; dir = 2'b10; ab_sel = '0; ba_sel = '0;
    a_in = 16'h9900; b_in = 16'h0077;
    #1 check_val("R1", {a_drv, b_drv}, {2'b01, 2'b10});
    check_val("R1", {a_out, b_out}, {16'h0077, 16'h9900});
    check_val("R11", {a_out[15:8], b_out[7:0]}, 16'h0000);
    check_all("R1");

    // Reset clears stored data (R10)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; oe_n = '0; dir = '1; ab_sel = '1;
    #1 check_val("R10", b_out, '0);

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rst_n  = ($urandom_range(63) != 0);
      oe_n   = L'($urandom_range(3) == 0 ? '1 : $urandom);
      dir    = L'($urandom); ab_sel = L'($urandom); ba_sel = L'($urandom);
      ab_cap = L'($urandom); ba_cap = L'($urandom);
      a_in   = (L*W)'($urandom); b_in = (L*W)'($urandom);
      check_all("");
    end
    finish_run();
  end
endmodule